// File: doc/BRIEF.md
# SPI Diagnostic Readout Port

This block is the serial slave side of a four-channel low-side driver's fault logic. A host selects it with an active-low chip select, toggles a serial clock and reads one 8-bit word. Each channel has a 2-bit status field in that word. The block never drives the physical pins directly. A fast system clock oversamples chip select, serial clock and serial data in. The block returns a serial data bit and an output-enable that together form a tri-stateable data-out pin.

When a frame opens, the data-out line carries a summary flag that tells the host whether any fault is stored. The first rising serial clock edge copies the fault register into the shift register. The same edge emits a one-clock clear pulse back to the fault register, so faults that appear during the read are still recorded for the next frame. The stored word then leaves most significant bit first. Bits received on serial data in are shifted in behind it and come out after the eighth bit. They configure nothing. Chip-select pulses shorter than a programmable number of system clocks are discarded. An undervoltage input and the reset both keep data-out in high impedance.

Top module: `spi_diag_port`

## Requirements
- R1: While `rstN` is low, `sdoEnable` and `faultClr` are 0. Any frame in progress is abandoned.
- R2: `sdoEnable` is 1 only while the filtered chip select is low. After `csN` returns high, `sdoEnable` returns to 0.
- R3: When a frame opens, `sdoData` equals the OR of all bits of `faultIn`: 1 if any fault is stored, 0 if none.
- R4: The first rising `sclk` edge of a frame raises `faultClr` for exactly one system clock. No further pulse occurs until chip select is released and asserted again.
- R5: Rising `sclk` edges 1 to 8 present `faultIn` bits 7 down to 0 on `sdoData`, as sampled at the first edge. Bits 7:6 belong to channel 1, 5:4 to channel 2, 3:2 to channel 3 and 1:0 to channel 4. Within each field, 11 means healthy, 10 means open load while on, 01 means short to supply or overtemperature, and 00 means short to ground while off.
- R6: `mosi` is captured on each falling `sclk` edge after the snapshot. From rising edge 9 onward, `sdoData` returns the captured bits in arrival order.
- R7: A low pulse on `csN` shorter than `CS_FILT_CYCLES` system clocks opens no frame: `sdoEnable` stays 0 and no clear pulse is issued.
- R8: Changes on `faultIn` after the first rising edge do not alter the bits shifted out in that frame.
- R9: While `uvLockout` is 1, `sdoEnable` and `faultClr` are 0 and `sclk` edges have no effect.
- R10: `sclk` edges while chip select is high produce no `faultClr` pulse and leave `sdoEnable` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvLockout | input | 1 | Supply undervoltage indication; forces data-out off |
| csN | input | 1 | Active-low chip select pin |
| sclk | input | 1 | Serial clock pin, idle low |
| mosi | input | 1 | Serial data in pin |
| faultIn | input | FRAME_BITS | Current contents of the fault register |
| faultClr | output | 1 | One-clock clear request to the fault register |
| sdoData | output | 1 | Serial data-out value |
| sdoEnable | output | 1 | Data-out drive enable; 0 means high impedance |

## Verification
A change on `sclk` or `mosi` passes two synchronizer flops and one edge-detect register, so its effect on `sdoData` or `faultClr` appears in the third system clock after the pin moves. A change on `csN` additionally waits `CS_FILT_CYCLES` clocks in the glitch filter. The bench moves pins on the falling system edge and samples outputs on a falling edge six clocks later for serial clock events and twelve clocks later for chip-select events, so every sample lands after the due cycle and before the next stimulus. The clear pulse is counted on every falling system edge, which catches both a missing pulse and a duplicate.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

  // Strobes the control side hands to the datapath each system clock
  typedef struct packed {
    logic loadSummary; // frame opened: present fault summary flag
    logic loadSnap;    // first rising sclk: copy fault register
    logic shiftOut;    // later rising sclk: advance to next bit
    logic captureIn;   // falling sclk: latch serial input bit
  } dpStrobe_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[0] <= RESET_VAL;
        else       stage[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[gi] <= RESET_VAL;
        else       stage[gi] <= stage[gi-1];
      end
    end
  end

  assign pinSync = stage[STAGES-1];

endmodule

// File: rtl/spi_diag_ctrl.sv
module spi_diag_ctrl import spi_diag_pkg::*; #(
  parameter int CS_FILT_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hold,
  input  logic      csSyncN,
  input  logic      sclkSync,
  output dpStrobe_t strobe,
  output logic      faultClr,
  output logic      sdoEnable
);

  localparam int CW = $clog2(CS_FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CS_FILT_CYCLES - 1);

  logic          csFiltN;
  logic [CW-1:0] filtCnt;
  logic          sclkPrev;
  logic          firstDone;

  logic csDiffer, csCommit, frameOn, sclkRise, sclkFall;

  always_comb begin
    csDiffer = (csSyncN != csFiltN);
    csCommit = csDiffer && (filtCnt == CNT_LAST);
    frameOn  = !csFiltN && !hold;
    sclkRise = frameOn && sclkSync && !sclkPrev;
    sclkFall = frameOn && !sclkSync && sclkPrev;

    strobe.loadSummary = csCommit && !csSyncN && !hold;
    strobe.loadSnap    = sclkRise && !firstDone;
    strobe.shiftOut    = sclkRise && firstDone;
    strobe.captureIn   = sclkFall && firstDone;

    faultClr  = strobe.loadSnap;
    sdoEnable = frameOn;
  end

  // Chip-select glitch filter: commit only after a run of equal samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csFiltN <= 1'b1;
      filtCnt <= '0;
    end else if (!csDiffer) begin
      filtCnt <= '0;
    end else if (csCommit) begin
      filtCnt <= '0;
      csFiltN <= csSyncN;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // Serial clock edge memory and frame progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      firstDone <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      if (csFiltN || hold)      firstDone <= 1'b0;
      else if (strobe.loadSnap) firstDone <= 1'b1;
    end
  end

  if (CS_FILT_CYCLES >= 2) begin : g_filt_chk
    // R7: the filtered select only moves after the raw sample agreed twice
    assert_filter_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
      (csFiltN != $past(csFiltN)) |->
        ($past(csSyncN) == csFiltN && $past(csSyncN, 2) == csFiltN));
  end

  assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> !faultClr);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> (!sdoEnable && !faultClr));

  assert_open_no_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEnable) |-> !faultClr);

endmodule

// File: rtl/spi_diag_dp.sv
module spi_diag_dp import spi_diag_pkg::*; #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  mosiSync,
  input  logic [FRAME_BITS-1:0] faultIn,
  output logic                  sdoData
);

  localparam int MSB = FRAME_BITS - 1;

  logic [MSB:0] shiftReg;
  logic         inBit;
  logic         outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
      inBit    <= 1'b0;
    end else begin
      if (strobe.loadSummary) begin
        outBit <= |faultIn;
      end else if (strobe.loadSnap) begin
        shiftReg <= faultIn;
        outBit   <= faultIn[MSB];
      end else if (strobe.shiftOut) begin
        outBit   <= shiftReg[MSB-1];
        shiftReg <= {shiftReg[MSB-1:0], inBit};
      end
      if (strobe.captureIn) inBit <= mosiSync;
    end
  end

  assign sdoData = outBit;

  assert_summary_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSummary |=> (sdoData == $past(|faultIn)));

  assert_first_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSnap |=> (sdoData == $past(faultIn[MSB])));

endmodule

// File: rtl/spi_diag_port.sv
module spi_diag_port import spi_diag_pkg::*; #(
  parameter int FRAME_BITS = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CS_FILT_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  uvLockout,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] faultIn,
  output logic                  faultClr,
  output logic                  sdoData,
  output logic                  sdoEnable
);

  logic [2:0] pinSync;
  dpStrobe_t  strobe;

  // order {mosi, sclk, csN}; select idles high
  spi_pin_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b001)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  ({mosi, sclk, csN}),
    .pinSync(pinSync)
  );

  spi_diag_ctrl #(
    .CS_FILT_CYCLES(CS_FILT_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (uvLockout),
    .csSyncN  (pinSync[0]),
    .sclkSync (pinSync[1]),
    .strobe   (strobe),
    .faultClr (faultClr),
    .sdoEnable(sdoEnable)
  );

  spi_diag_dp #(
    .FRAME_BITS(FRAME_BITS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mosiSync(pinSync[2]),
    .faultIn (faultIn),
    .sdoData (sdoData)
  );

endmodule

// File: tb/test_spi_diag_port.sv
module test_spi_diag_port;

  localparam int CLK_PERIOD = 10;
  localparam int EDGE_WAIT = 6;
  localparam int CS_WAIT = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uvLockout = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic [7:0] faultIn = 8'h00;
  logic       faultClr, sdoData, sdoEnable;

  int checks = 0;
  int fails = 0;
  int clrSeen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_diag_port #(
    .FRAME_BITS(8), .SYNC_STAGES(2), .CS_FILT_CYCLES(4)
  ) i_spi_diag_port (
    .clk(clk), .rstN(rstN), .uvLockout(uvLockout), .csN(csN), .sclk(sclk),
    .mosi(mosi), .faultIn(faultIn), .faultClr(faultClr),
    .sdoData(sdoData), .sdoEnable(sdoEnable)
  );

  always @(negedge clk) if (faultClr) clrSeen++;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic runFrame(input logic [7:0] v);
    int clrBase;
    logic [7:0] inBits;
    inBits = ~v;
    faultIn = v;
    mosi = 1'b0;
    clrBase = clrSeen;
    csN = 1'b0;
    waitClk(CS_WAIT);
    check("R2 enable in frame", sdoEnable, 1);
    check("R3 summary flag", sdoData, int'(|v));
    check("R4 no clear before clock", clrSeen - clrBase, 0);
    for (int k = 1; k <= 10; k++) begin
      sclk = 1'b1;
      waitClk(EDGE_WAIT);
      if (k <= 8) check("R5 R8 data bit", sdoData, int'(v[8-k]));
      else        check("R6 echoed input", sdoData, int'(inBits[k-9]));
      if (k == 1) begin
        check("R4 clear on first edge", clrSeen - clrBase, 1);
        faultIn = ~v;
      end
      mosi = inBits[(k-1) % 8];
      sclk = 1'b0;
      waitClk(EDGE_WAIT);
    end
    check("R4 single clear per frame", clrSeen - clrBase, 1);
    csN = 1'b1;
    waitClk(CS_WAIT);
    check("R2 released select", sdoEnable, 0);
  endtask

  initial begin
    waitClk(3);
    check("R1 reset enable", sdoEnable, 0);
    check("R1 reset clear", faultClr, 0);
    rstN = 1'b1;
    waitClk(4);
    check("R2 idle enable", sdoEnable, 0);

    // sweep every fault pattern
    for (int v = 0; v < 256; v++) runFrame(8'(v));

    // R7: short select glitch
    begin
      int base;
      base = clrSeen;
      csN = 1'b0; waitClk(2); csN = 1'b1;
      waitClk(4);
      check("R7 glitch enable", sdoEnable, 0);
      sclk = 1'b1; waitClk(EDGE_WAIT); sclk = 1'b0; waitClk(EDGE_WAIT);
      check("R7 glitch clear", clrSeen - base, 0);
    end

    // R10: clocks with select high
    begin
      int base;
      base = clrSeen;
      for (int i = 0; i < 3; i++) begin
        sclk = 1'b1; waitClk(EDGE_WAIT); sclk = 1'b0; waitClk(EDGE_WAIT);
      end
      check("R10 idle clocks clear", clrSeen - base, 0);
      check("R10 idle clocks enable", sdoEnable, 0);
    end

    // R9: undervoltage during a frame
    begin
      int base;
      faultIn = 8'h5A;
      base = clrSeen;
      csN = 1'b0; waitClk(CS_WAIT);
      check("R9 frame open", sdoEnable, 1);
      uvLockout = 1'b1; waitClk(2);
      check("R9 lockout enable", sdoEnable, 0);
      sclk = 1'b1; waitClk(EDGE_WAIT);
      check("R9 lockout clear", clrSeen - base, 0);
      sclk = 1'b0; waitClk(EDGE_WAIT);
      uvLockout = 1'b0;
      csN = 1'b1; waitClk(CS_WAIT);
    end

    // R1: reset in the middle of a frame
    begin
      faultIn = 8'hC3;
      csN = 1'b0; waitClk(CS_WAIT);
      sclk = 1'b1; waitClk(EDGE_WAIT);
      rstN = 1'b0; waitClk(2);
      check("R1 mid-frame reset enable", sdoEnable, 0);
      check("R1 mid-frame reset clear", faultClr, 0);
      sclk = 1'b0; csN = 1'b1; waitClk(2);
      rstN = 1'b1; waitClk(CS_WAIT);
      runFrame(8'hC3);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule